// File: doc/BRIEF.md
# Sync-Framed Streaming Histogram Accumulator

This block builds a histogram of a sample stream. Every accepted sample is sorted into a bin chosen by its top bits, and that bin's counter is incremented. Counting is organised in frames. A frame starts with a pulse on the sync input and ends with the next one.

Two count banks take turns. One bank accumulates the frame in progress. The other holds the finished histogram of the frame before and can be read through a small memory-style read port (address, read strobe, read data, read-valid). At each sync the roles swap. The bank that starts accumulating has its contents discarded in the same cycle, so every frame starts from zero.

For two's-complement input, the most significant index bit is inverted. The read addresses therefore run from the most negative level range up to the most positive one.

Top module: `stream_histogram`

## Requirements
- R1: Synchronous active-low reset empties both banks and returns bank selection to its initial state. Afterwards every bin reads 0 and `rd_valid` is low while no read is pending.
- R2: Valid samples that arrive before the first sync after reset are not counted. Until one full frame has completed, every bin reads 0.
- R3: With `SIGNED_DATA=1`, the bin of a sample is its top log2(`NBINS`) bits with the most significant of those bits inverted. So with 8-bit data and 16 bins, 0x80 lands in bin 0, 0x00 in bin 8 and 0x7F in bin 15. Each bin spans 2^`DATA_W`/`NBINS` levels.
- R4: After a frame completes, reading bin b returns the number of valid samples of that frame that fell in bin b. The counts over all bins add up to the frame's valid-sample total.
- R5: Valid samples that hit the same bin on consecutive cycles are all counted. A frame of `FRAME_LEN` identical samples reads exactly `FRAME_LEN` in one bin and 0 elsewhere. Counters are ceil(log2(`FRAME_LEN`+1)) bits wide.
- R6: Samples presented with `in_valid` low change no count, whatever their data.
- R7: A valid sample presented in the same cycle as `in_sync` is counted in the frame that this sync opens.
- R8: Every sync swaps the banks. The read port always shows the most recently completed frame, and a completed frame with no valid samples reads 0 in every bin.
- R9: `rd_valid` is high exactly one cycle after a cycle with `rd_en` high, and `rd_data` carries the addressed bin in that cycle. `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stream and read port |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` |
| in_sync | input | 1 | Frame start pulse |
| in_data | input | DATA_W | Sample value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | log2(NBINS) | Bin index to read |
| rd_valid | output | 1 | Read data qualifier, one cycle after `rd_en` |
| rd_data | output | ceil(log2(FRAME_LEN+1)) | Count of the addressed bin in the completed frame |

## Verification
The checker assumes that no more than `FRAME_LEN` valid samples arrive between two syncs. Under that assumption, any bin count written must lie between 1 and `FRAME_LEN`. The checker also assumes that sync pulses mark frame starts and that reads are not issued in a sync cycle when a specific frame's result is wanted.

The bench stays within these assumptions. Every frame it sends is exactly `FRAME_LEN` cycles long and is opened by a single sync. All reads happen while the stream is idle, after the closing sync. Samples sent before the first sync are the only traffic outside a frame.

// File: rtl/hist_pkg.sv
// Package: shared constants and width helpers for the histogram block.
// Assumes: two count banks; counter width chosen so a full frame fits.
package hist_pkg;
    localparam int NUM_BANKS = 2;

    // Width needed to hold any value from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/hist_binner.sv
// Module: hist_binner
// Maps a sample to its bin index by taking the top IDX_W bits. For signed
// input the top index bit is inverted so bin 0 holds the most negative range.
// Assumes: DATA_W >= IDX_W >= 1.
module hist_binner #(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 4,
    parameter bit SIGNED_DATA = 1'b1
) (
    input  logic [DATA_W-1:0] sample,
    output logic [IDX_W-1:0]  bin
);
    localparam int SHIFT = DATA_W - IDX_W;

    generate
        if (SIGNED_DATA) begin : g_offset
            localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);
            // Offset-binary index: top bits with sign bit flipped.
            always_comb bin = IDX_W'(sample >> SHIFT) ^ FLIP;
        end else begin : g_plain
            // Unsigned index: top bits as they are.
            always_comb bin = IDX_W'(sample >> SHIFT);
        end
    endgenerate
endmodule

// File: rtl/hist_frame_ctrl.sv
// Module: hist_frame_ctrl
// Tracks which bank accumulates, arms counting at the first sync, decides
// which bank an incoming sample belongs to and when a bank is emptied.
// Assumes: in_sync is a single-cycle pulse per frame start.
module hist_frame_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sync,
    output logic bank_sel,
    output logic armed,
    output logic smp_ok,
    output logic smp_bank,
    output logic rd_bank,
    output logic [hist_pkg::NUM_BANKS-1:0] clr
);
    // Swap bank roles on every sync; arm counting from the first sync on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;
            armed    <= 1'b0;
        end else if (in_sync) begin
            bank_sel <= ~bank_sel;
            armed    <= 1'b1;
        end
    end

    // Sample acceptance and destination bank, sync cycle goes to the new bank.
    always_comb begin
        smp_ok   = in_valid && (armed || in_sync);
        smp_bank = in_sync ? ~bank_sel : bank_sel;
        rd_bank  = ~bank_sel;
    end

    // Empty the bank that starts accumulating at this sync.
    always_comb begin
        for (int b = 0; b < hist_pkg::NUM_BANKS; b++) begin
            clr[b] = in_sync && (smp_bank == 1'(b));
        end
    end
endmodule

// File: rtl/hist_bank.sv
// Module: hist_bank
// One count bank: a register file with one write port, a count-side read
// port and a bus-side read port, both with one cycle of read latency.
// A per-bin occupied flag lets the whole bank be emptied in one cycle.
// Assumes: clr and a write never target this bank in the same cycle; a
// read and a write of one address in one cycle return the old value.
module hist_bank #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [CNT_W-1:0]  a_data,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [CNT_W-1:0]  b_data
);
    logic [CNT_W-1:0] mem  [DEPTH];
    logic [DEPTH-1:0] used;

    // Occupied flags: cleared by reset or clr, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else begin
            if (clr) used <= '0;
            if (wr_en) used[wr_addr] <= 1'b1;
        end
    end

    // Count storage; unoccupied entries are never read out.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Count-side read; a bank being emptied reads as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_data <= '0;
        end else begin
            a_data <= (clr || !used[a_addr]) ? '0 : mem[a_addr];
        end
    end

    // Bus-side read of the state before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_data <= '0;
        end else begin
            b_data <= used[b_addr] ? mem[b_addr] : '0;
        end
    end
endmodule

// File: rtl/hist_accum.sv
// Module: hist_accum
// Read-modify-write increment pipeline. Stage 1 holds the sample while the
// bank read completes; the increment is written at the end of stage 1.
// The previous write is kept one cycle and forwarded when the next sample
// hits the same bank and bin, so back-to-back hits are never lost.
// Assumes: bank read data arrives one cycle after the address.
module hist_accum #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 7
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        smp_ok,
    input  logic                                        smp_bank,
    input  logic [IDX_W-1:0]                            smp_bin,
    input  logic [hist_pkg::NUM_BANKS-1:0][CNT_W-1:0]   bank_q,
    output logic                                        wr_en,
    output logic                                        wr_bank,
    output logic [IDX_W-1:0]                            wr_bin,
    output logic [CNT_W-1:0]                            wr_cnt
);
    logic             s1_ok;
    logic             s1_bank;
    logic [IDX_W-1:0] s1_bin;
    logic             lw_ok;
    logic             lw_bank;
    logic [IDX_W-1:0] lw_bin;
    logic [CNT_W-1:0] lw_cnt;
    logic             fwd;
    logic [CNT_W-1:0] base;

    // Stage 1 register of the accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ok   <= 1'b0;
            s1_bank <= 1'b0;
            s1_bin  <= '0;
        end else begin
            s1_ok   <= smp_ok;
            s1_bank <= smp_bank;
            s1_bin  <= smp_bin;
        end
    end

    // Hold the last write for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_ok   <= 1'b0;
            lw_bank <= 1'b0;
            lw_bin  <= '0;
            lw_cnt  <= '0;
        end else begin
            lw_ok   <= wr_en;
            lw_bank <= wr_bank;
            lw_bin  <= wr_bin;
            lw_cnt  <= wr_cnt;
        end
    end

    // Pick the freshest count and add one.
    always_comb begin
        fwd     = lw_ok && (lw_bank == s1_bank) && (lw_bin == s1_bin);
        base    = fwd ? lw_cnt : bank_q[s1_bank];
        wr_en   = s1_ok;
        wr_bank = s1_bank;
        wr_bin  = s1_bin;
        wr_cnt  = base + CNT_W'(1);
    end
endmodule

// File: rtl/stream_histogram.sv
// Module: stream_histogram (top)
// Histogram of a valid-qualified stream, framed by sync, with two banks
// swapping roles at every sync and a registered read port on the bank
// that holds the last completed frame.
// Assumes: NBINS is a power of two, NBINS <= 2**DATA_W, at most FRAME_LEN
// valid samples per frame.
module stream_histogram #(
    parameter int DATA_W      = 8,
    parameter int NBINS       = 16,
    parameter int FRAME_LEN   = 64,
    parameter bit SIGNED_DATA = 1'b1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      in_valid,
    input  logic                                      in_sync,
    input  logic [DATA_W-1:0]                         in_data,
    input  logic                                      rd_en,
    input  logic [$clog2(NBINS)-1:0]                  rd_addr,
    output logic                                      rd_valid,
    output logic [hist_pkg::cnt_width(FRAME_LEN)-1:0] rd_data
);
    localparam int IDX_W = $clog2(NBINS);
    localparam int CNT_W = hist_pkg::cnt_width(FRAME_LEN);
    localparam int NB    = hist_pkg::NUM_BANKS;

    logic                       bank_sel;
    logic                       armed;
    logic                       smp_ok;
    logic                       smp_bank;
    logic                       rd_bank;
    logic [NB-1:0]              clr;
    logic [IDX_W-1:0]           smp_bin;
    logic [NB-1:0][CNT_W-1:0]   a_q;
    logic [NB-1:0][CNT_W-1:0]   b_q;
    logic                       wr_en;
    logic                       wr_bank;
    logic [IDX_W-1:0]           wr_bin;
    logic [CNT_W-1:0]           wr_cnt;
    logic                       rd_bank_q;
    logic                       rd_valid_q;

    hist_binner #(
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .SIGNED_DATA (SIGNED_DATA)
    ) u_binner (
        .sample (in_data),
        .bin    (smp_bin)
    );

    hist_frame_ctrl u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .bank_sel (bank_sel),
        .armed    (armed),
        .smp_ok   (smp_ok),
        .smp_bank (smp_bank),
        .rd_bank  (rd_bank),
        .clr      (clr)
    );

    hist_accum #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_ok   (smp_ok),
        .smp_bank (smp_bank),
        .smp_bin  (smp_bin),
        .bank_q   (a_q),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_bin   (wr_bin),
        .wr_cnt   (wr_cnt)
    );

    generate
        for (genvar g = 0; g < NB; g++) begin : g_bank
            hist_bank #(
                .DEPTH  (NBINS),
                .CNT_W  (CNT_W),
                .ADDR_W (IDX_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr[g]),
                .wr_en   (wr_en && (wr_bank == 1'(g))),
                .wr_addr (wr_bin),
                .wr_data (wr_cnt),
                .a_addr  (smp_bin),
                .a_data  (a_q[g]),
                .b_addr  (rd_addr),
                .b_data  (b_q[g])
            );
        end
    endgenerate

    // Read port pipeline: remember the bank read and flag valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bank_q  <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_bank_q  <= rd_bank;
            rd_valid_q <= rd_en;
        end
    end

    // Present the selected bank's count only while valid.
    always_comb begin
        rd_valid = rd_valid_q;
        rd_data  = rd_valid_q ? b_q[rd_bank_q] : '0;
    end
endmodule

// File: rtl/hist_checker.sv
// Module: hist_checker
// Temporal properties of stream_histogram, attached by bind.
// Assumes: no more than FRAME_LEN valid samples between syncs.
module hist_checker #(
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 7,
    parameter int FRAME_LEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sync,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             armed,
    input logic             bank_sel,
    input logic             wr_en,
    input logic             wr_bank,
    input logic [IDX_W-1:0] wr_bin,
    input logic [CNT_W-1:0] wr_cnt
);
    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_bank_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |=> (bank_sel != $past(bank_sel)));

    assert_prearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !in_sync) |=> !wr_en);

    assert_ignore_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_en);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cnt != '0) && (int'(wr_cnt) <= FRAME_LEN));

    assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && (wr_bank == $past(wr_bank)) && (wr_bin == $past(wr_bin)))
        |-> (wr_cnt == $past(wr_cnt) + CNT_W'(1)));
endmodule

bind stream_histogram hist_checker #(
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W),
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .armed    (armed),
    .bank_sel (bank_sel),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_bin   (wr_bin),
    .wr_cnt   (wr_cnt)
);

// File: tb/sim_stream_histogram.sv
`timescale 1ns/1ps
// Directed bench for stream_histogram: one task per scenario.
module sim_stream_histogram;
    localparam int DW  = 8;
    localparam int NBN = 16;
    localparam int FL  = 64;
    localparam int IW  = 4;
    localparam int CW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sync = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  exp_h [NBN];
    logic [DW-1:0] smp [FL];
    bit  vld [FL];

    always #2.5 clk = ~clk;

    stream_histogram #(
        .DATA_W(DW), .NBINS(NBN), .FRAME_LEN(FL), .SIGNED_DATA(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Bin per R3: top 4 bits, top one inverted.
    function automatic int bin_of(input logic [DW-1:0] s);
        return ((int'(s) >> 4) ^ 8) & 15;
    endfunction

    task automatic drive(input bit v, input bit s, input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_sync  = s;
        in_data  = d;
    endtask

    task automatic read_bin(input int addr, output int val);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = IW'(addr);
        @(negedge clk);
        val   = rd_valid ? int'(rd_data) : -1;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0; in_sync = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send the prepared frame with sync on its first cycle and model it.
    task automatic send_frame();
        for (int b = 0; b < NBN; b++) exp_h[b] = 0;
        for (int i = 0; i < FL; i++) begin
            drive(vld[i], i == 0, smp[i]);
            if (vld[i]) exp_h[bin_of(smp[i])]++;
        end
    endtask

    // Close the frame with an empty sync, then read and compare every bin.
    task automatic close_and_check(input string tag);
        int v;
        int sum = 0;
        int tot = 0;
        drive(1'b0, 1'b1, '0);
        drive(1'b0, 1'b0, '0);
        for (int b = 0; b < NBN; b++) begin
            read_bin(b, v);
            chk($sformatf("%s bin %0d", tag, b), v, exp_h[b]);
            sum += v;
            tot += exp_h[b];
        end
        chk({tag, " sum of bins R4"}, sum, tot);
    endtask

    task automatic read_all_zero(input string tag);
        int v;
        for (int b = 0; b < NBN; b++) begin
            read_bin(b, v);
            chk($sformatf("%s bin %0d", tag, b), v, 0);
        end
    endtask

    task automatic t_reset_state();
        chk("R1 rd_valid low after reset", int'(rd_valid), 0);
        read_all_zero("R1 reset");
    endtask

    task automatic t_latency();
        @(negedge clk);
        rd_en = 1'b1; rd_addr = '0;
        chk("R9 no valid in strobe cycle", int'(rd_valid), 0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 valid one cycle after strobe", int'(rd_valid), 1);
        @(negedge clk);
        chk("R9 valid drops without strobe", int'(rd_valid), 0);
    endtask

    task automatic t_prearm();
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 8'h00);
        drive(1'b0, 1'b1, '0);
        drive(1'b0, 1'b0, '0);
        read_all_zero("R2 pre-sync samples");
    endtask

    task automatic t_ramp();
        for (int i = 0; i < FL; i++) begin smp[i] = DW'(i * 4); vld[i] = 1'b1; end
        send_frame();
        close_and_check("R4 ramp");
        // bin 8 includes the sample sent with sync (value 0)
        begin
            int v;
            read_bin(8, v);
            chk("R7 sync-cycle sample counted", v, 4);
        end
    endtask

    task automatic t_dc_min();
        for (int i = 0; i < FL; i++) begin smp[i] = 8'h80; vld[i] = 1'b1; end
        send_frame();
        close_and_check("R5 R3 dc 0x80");
    endtask

    task automatic t_dc_max();
        for (int i = 0; i < FL; i++) begin smp[i] = 8'h7F; vld[i] = 1'b1; end
        send_frame();
        close_and_check("R8 R3 dc 0x7F");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < FL; i++) begin
            vld[i] = (i % 2) == 0;
            smp[i] = vld[i] ? 8'h10 : 8'h70;
        end
        send_frame();
        close_and_check("R6 invalid gaps");
    endtask

    task automatic t_lfsr();
        logic [7:0] st = 8'hA5;
        for (int i = 0; i < FL; i += 2) begin
            smp[i] = st; smp[i+1] = st; vld[i] = 1'b1; vld[i+1] = 1'b1;
            st = {st[6:0], st[7] ^ st[5] ^ st[4] ^ st[3]};
        end
        send_frame();
        close_and_check("R4 R5 paired random");
    endtask

    task automatic t_empty();
        drive(1'b0, 1'b1, '0);
        drive(1'b0, 1'b0, '0);
        read_all_zero("R8 empty frame");
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < FL; i++) begin smp[i] = 8'h00; vld[i] = 1'b1; end
        send_frame();
        close_and_check("R4 dc 0x00");
        do_reset();
        read_all_zero("R1 reset after data");
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_latency();
        t_prearm();
        t_ramp();
        t_dc_min();
        t_dc_max();
        t_gaps();
        t_lfsr();
        t_empty();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule